// File: doc/BRIEF.md
# Memory-Mapped Byte SPI Master

This block is a single-byte SPI master reached through two 32-bit word locations on a simple write-strobe bus. The control word sets three chip-select pin levels, a loopback switch and a five-bit clock divider, and it starts a transfer. Reading the control word returns the same fields plus a busy flag. The data word holds the byte to send and, once the transfer ends, the byte that was received.

Software writes the outgoing byte to the data location, then writes the whole control word with the start bit set. The block clocks eight bits out MSB first in SPI mode 0, samples the serial input on every rising SCK edge, and drops busy when the last falling edge completes. The chip-select pins are plain outputs whose levels software sets. The block does not sequence them.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, all three chip-select pins are 1, busy is 0, SCK is 0, the data word reads 0, and the control word reads 0x0000_0015.
- R2: The control word at offset 0x0 reads back as follows: chip select n at bit 2n (n = 0, 1, 2), loopback at bit 3, busy at bit 1, divider D at bits 31:27, and 0 in every other bit.
- R3: A control write with bit 1 set while idle starts a transfer, and busy reads 1 from the next clock cycle on.
- R4: A transfer moves exactly 8 bits MSB first in SPI mode 0. SCK idles low, MOSI changes only on falling SCK edges, and the serial input is sampled on rising edges.
- R5: Each SCK half period lasts D+1 reference cycles. Busy stays 1 for exactly 16×(D+1) cycles, and SCK is high for 8×(D+1) of them.
- R6: With bit 3 set, the received byte equals the transmitted byte and the MISO pin is ignored.
- R7: In the cycle where busy first reads 0, a read of offset 0x4 returns the received byte in bits 7:0, and bits 31:8 always read 0.
- R8: A control write with bit 1 clear updates only the chip-select levels, loopback and divider. Busy stays 0 and SCK stays low.
- R9: Control and data writes made while busy is 1 have no effect.
- R10: Each chip-select pin follows its control bit directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x4 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_lvl | output | 3 | Chip-select pin levels |

## Verification
The bench targets the slowest and fastest dividers, where an off-by-one error in the half-period counter shows up as a busy window of the wrong length. It writes new control and data words in the middle of a byte; a design that accepted them would change the chip-select pins or the divider mid-transfer, or corrupt the received byte. It reads the data word in the exact cycle busy drops; a design that updates the data one cycle late returns the transmitted byte there. Loopback runs against an opposing MISO pattern, so a design that still listened to the pin returns the wrong byte.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
    parameter int REG_W  = 32;
    parameter int DATA_W = 8;
    parameter int DIV_W  = 5;
    parameter int NUM_CS = 3;
    parameter int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(4);
    localparam int BIT_START = 1;
    localparam int BIT_LOOP  = 3;
    localparam int DIV_LSB   = REG_W - DIV_W;
    localparam int BITCNT_W  = $clog2(DATA_W);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              loop;
        logic [NUM_CS-1:0] cs;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c, logic busy);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_CS; i++) r[2*i] = c.cs[i];
        r[BIT_LOOP]  = c.loop;
        r[BIT_START] = busy;
        r[REG_W-1:DIV_LSB] = c.div;
        return r;
    endfunction

    function automatic ctrl_t unpack_ctrl(logic [REG_W-1:0] w);
        ctrl_t c;
        for (int i = 0; i < NUM_CS; i++) c.cs[i] = w[2*i];
        c.loop = w[BIT_LOOP];
        c.div  = w[REG_W-1:DIV_LSB];
        return c;
    endfunction
endpackage

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
    import spi_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              fin,
    input  logic [DATA_W-1:0] rx_byte,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] data_q,
    output logic              start,
    output logic [REG_W-1:0]  rdata
);
    logic wr_ok;
    logic unused_bits;

    assign wr_ok       = wr_en && !busy;
    assign start       = wr_ok && (addr == OFS_CTRL) && wdata[BIT_START];
    assign unused_bits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '{div: '0, loop: 1'b0, cs: '1};
            data_q <= '0;
        end else begin
            if (wr_ok && addr == OFS_CTRL) ctrl <= unpack_ctrl(wdata);
            if (wr_ok && addr == OFS_DATA) data_q <= wdata[DATA_W-1:0];
            if (fin) data_q <= rx_byte;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL) rdata = pack_ctrl(ctrl, busy);
        else if (addr == OFS_DATA) rdata[DATA_W-1:0] = data_q;
    end
endmodule

// File: rtl/spi_bm_clkdiv.sv
module spi_bm_clkdiv
    import spi_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt <= '0;
        else if (cnt == div)        cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter
    import spi_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx,
    input  logic              tick,
    input  logic              loop,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              fin,
    output logic [DATA_W-1:0] rx
);
    logic [DATA_W-1:0]   sh;
    logic [BITCNT_W-1:0] bitcnt;
    logic                last_bit;
    logic                sin;

    assign mosi     = sh[DATA_W-1];
    assign sin      = loop ? mosi : miso;
    assign last_bit = (bitcnt == BITCNT_W'(DATA_W-1));
    assign fin      = busy && tick && sck && last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sck    <= 1'b0;
            sh     <= '0;
            rx     <= '0;
            bitcnt <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            sck    <= 1'b0;
            sh     <= tx;
            bitcnt <= '0;
        end else if (busy && tick) begin
            if (!sck) begin
                sck <= 1'b1;
                rx  <= {rx[DATA_W-2:0], sin};
            end else begin
                sck <= 1'b0;
                if (last_bit) begin
                    busy <= 1'b0;
                end else begin
                    sh     <= {sh[DATA_W-2:0], 1'b0};
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_lvl
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rx_byte;
    logic              start;
    logic              busy;
    logic              fin;
    logic              tick;

    spi_bm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .busy(busy), .fin(fin), .rx_byte(rx_byte),
        .ctrl(ctrl), .data_q(data_q), .start(start), .rdata(bus_rdata)
    );

    spi_bm_clkdiv u_div (
        .clk(clk), .rst(rst), .restart(start), .run(busy), .div(ctrl.div), .tick(tick)
    );

    spi_bm_shifter u_shift (
        .clk(clk), .rst(rst), .start(start), .tx(data_q), .tick(tick),
        .loop(ctrl.loop), .miso(miso), .busy(busy), .sck(sck), .mosi(mosi),
        .fin(fin), .rx(rx_byte)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_lvl[i] = ctrl.cs[i];
    end
endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker
    import spi_bm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              sck,
    input logic [NUM_CS-1:0] cs_lvl,
    input logic              busy
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cs_lvl == '1 && !sck && !busy));

    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[BIT_START] && !busy) |=> busy);

    a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    a_r8_no_start_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && !bus_wdata[BIT_START] && !busy) |=> !busy);

    a_r9_cs_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cs_lvl));

    a_r7_data_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_DATA) |-> (bus_rdata[REG_W-1:DATA_W] == '0));
endmodule

bind spi_byte_master spi_bm_checker chk (.*);

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso;
    logic [2:0]  cs_lvl;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [7:0] slv = '0;
    logic [7:0] cap = '0;
    int         rises = 0;

    always #2 clk = ~clk;

    spi_byte_master uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_lvl(cs_lvl)
    );

    assign miso = slv[7];
    always @(negedge sck) slv <= {slv[6:0], 1'b0};
    always @(posedge sck) begin
        cap   <= {cap[6:0], mosi};
        rises <= rises + 1;
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(logic [2:0] cs, logic lp, logic [4:0] d, logic st);
        logic [31:0] w;
        w = '0;
        w[0] = cs[0]; w[2] = cs[1]; w[4] = cs[2];
        w[3] = lp; w[1] = st; w[31:27] = d;
        return w;
    endfunction

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run_xfer(logic [7:0] tx, logic [7:0] sb, logic [4:0] d,
                            logic lp, logic [2:0] cs, bit poke);
        int n, hi;
        logic [7:0] exp_rx;
        exp_rx = lp ? tx : sb;
        bus_write(4'h4, {24'h0, tx});
        slv = sb; rises = 0;
        bus_write(4'h0, ctrl_word(cs, lp, d, 1'b1));
        bus_addr = 4'h0; #1;
        check(bus_rdata[1] == 1'b1, "R3 busy after start", bus_rdata, 32'h2);
        check(bus_rdata == ctrl_word(cs, lp, d, 1'b1), "R2 ctrl readback busy", bus_rdata,
              ctrl_word(cs, lp, d, 1'b1));
        n = 0; hi = 0;
        if (poke) begin
            n = 2; hi = 0;
            bus_write(4'h0, ctrl_word(~cs, ~lp, d + 5'd1, 1'b1));
            bus_write(4'h4, 32'h0000_00C3);
        end
        forever begin
            bus_addr = 4'h0; #1;
            if (!bus_rdata[1] || n > 2000) break;
            n++;
            if (sck) hi++;
            @(negedge clk);
        end
        bus_addr = 4'h4; #1;
        check(bus_rdata == {24'h0, exp_rx}, lp ? "R6 loopback rx" : "R7 rx at busy clear",
              bus_rdata, {24'h0, exp_rx});
        check(n == 16 * (d + 1), "R5 busy length", n, 16 * (d + 1));
        check(hi == 8 * (d + 1), "R5 sck high time", hi, 8 * (d + 1));
        check(cap == tx && rises == 8, "R4 mosi msb first", {cap, 24'(rises)}, {tx, 24'd8});
        check(sck == 1'b0, "R4 sck idle low", sck, 0);
        check(cs_lvl == cs, "R10 cs pins", cs_lvl, cs);
        bus_addr = 4'h0; #1;
        if (poke)
            check(bus_rdata == ctrl_word(cs, lp, d, 1'b0), "R9 ctrl write ignored while busy",
                  bus_rdata, ctrl_word(cs, lp, d, 1'b0));
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R5 watchdog act=0x%08h exp=0x%08h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bus_addr = 4'h0; #1;
        check(bus_rdata == 32'h0000_0015, "R1 ctrl after reset", bus_rdata, 32'h15);
        check(cs_lvl == 3'b111 && sck == 1'b0, "R1 pins after reset", {cs_lvl, sck}, 4'b1110);
        bus_addr = 4'h4; #1;
        check(bus_rdata == 32'h0, "R1 data after reset", bus_rdata, 0);
        @(negedge clk);

        // R8: control write without start
        bus_write(4'h0, ctrl_word(3'b010, 1'b1, 5'd9, 1'b0));
        for (int i = 0; i < 20; i++) begin
            bus_addr = 4'h0; #1;
            check(bus_rdata[1] == 1'b0 && sck == 1'b0, "R8 no transfer", bus_rdata, 0);
            @(negedge clk);
        end
        bus_addr = 4'h0; #1;
        check(bus_rdata == ctrl_word(3'b010, 1'b1, 5'd9, 1'b0), "R8 fields updated", bus_rdata,
              ctrl_word(3'b010, 1'b1, 5'd9, 1'b0));
        check(cs_lvl == 3'b010, "R10 cs follows bits", cs_lvl, 3'b010);
        bus_write(4'h0, 32'hFFFF_FFFD);
        bus_addr = 4'h0; #1;
        check(bus_rdata == 32'hF800_001D, "R2 unused bits read zero", bus_rdata, 32'hF800_001D);
        @(negedge clk);

        run_xfer(8'hA5, 8'h3C, 5'd0, 1'b0, 3'b110, 1'b0);
        run_xfer(8'h81, 8'h7E, 5'd31, 1'b0, 3'b011, 1'b0);
        run_xfer(8'h5A, 8'hFF, 5'd2, 1'b1, 3'b101, 1'b0);
        run_xfer(8'h96, 8'h00, 5'd3, 1'b0, 3'b000, 1'b1);
        run_xfer(8'h0F, 8'hE1, 5'd4, 1'b1, 3'b111, 1'b1);

        for (int k = 0; k < 24; k++) begin
            run_xfer(8'($urandom), 8'($urandom), 5'($urandom_range(0, 7)),
                     1'($urandom), 3'($urandom), 1'b0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule